// File: doc/BRIEF.md
# Handshake Interrupt Combiner

This block sits between the serial interface engine of a USB device controller and the interrupt pin that goes to an external microprocessor. Each cycle the engine may present one handshake event: ACK, NAK or STALL, whether received or sent. The event carries an endpoint number and a direction. Three filter fields in a one-byte configuration register decide which handshake kinds count. One field covers the control endpoint, one covers the IN data endpoints and one covers the OUT data endpoints.

An event that passes the filter sets a sticky pending flag for its source. Software clears a flag by writing 1 to it. Each source has an enable bit. A global enable gates the pin as a whole. The pin either holds a level while any enabled flag is pending, or gives a short pulse that is a fixed number of clock cycles long. A polarity bit sets the active sense in both modes.

Turning the global enable on while an enabled flag is already pending drives the pin at the next clock edge.

Top module: `irq_out_gen`

## Requirements
- R1: After synchronous reset all pending flags are 0, the configuration register reads 0x00, and `int_pin` is 1. This is the inactive level for the reset polarity, which is active low.
- R2: The configuration byte is laid out as follows, and `cfg_rd` returns the byte last written.
  - Bits [1:0]: filter for the control endpoint (endpoint 0).
  - Bits [3:2]: filter for IN endpoints 1 and up.
  - Bits [5:4]: filter for OUT endpoints 1 and up.
  - Bit 6: polarity, where 1 means active high.
  - Bit 7: mode, where 1 means pulse.
- R3: Filter encoding. Event kinds are 0 = ACK, 1 = NAK, 2 = STALL.
  - 00 accepts ACK only.
  - 01 accepts ACK and NAK.
  - 10 accepts ACK and STALL.
  - 11 accepts all three.
  - The control endpoint uses its own field in both directions.
- R4: For endpoints 1 and up, an event with `ev_in`=1 uses the IN field and an event with `ev_in`=0 uses the OUT field. An accepted event sets pending bit endpoint*2+`ev_in` at the clock edge that samples it.
- R5: Event kind 3 is never accepted and sets no flag.
- R6: Writing 1 to a `clr_mask` bit with `clr_we` clears that flag at the next edge. A set and a clear of the same flag in one cycle leave it set.
- R7: A flag whose `src_en` bit is 0 is still recorded, but it does not drive the pin. Enabling it in level mode makes the pin active at the next edge.
- R8: With `glb_en` at 0 the pin stays inactive, while flags are still recorded.
- R9: When `glb_en` rises while an enabled flag is pending, the pin becomes active at the next edge. This holds in level mode and starts a pulse in pulse mode.
- R10: In level mode the pin is active from the edge that sets an enabled flag until the edge that clears the last enabled flag. The active level follows the polarity bit.
- R11: In pulse mode an accepted, enabled event with `glb_en`=1 makes the pin active for exactly PULSE_CYC cycles. PULSE_CYC is 3 at the defaults, and the active level follows the polarity bit.
- R12: In pulse mode, an event that arrives during a pulse is merged into it. The pulse is neither lengthened nor repeated.
- R13: In pulse mode, events that arrive while `glb_en`=0 produce no pulse by themselves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid | input | 1 | Handshake event strobe |
| ev_ep | input | 3 | Endpoint number of the event |
| ev_in | input | 1 | 1 = IN direction, 0 = OUT |
| ev_kind | input | 2 | 0 = ACK, 1 = NAK, 2 = STALL, 3 = none |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| src_en | input | 16 | Per-source enable, bit endpoint*2+direction |
| glb_en | input | 1 | Global interrupt enable |
| clr_we | input | 1 | Write strobe for clearing pending flags |
| clr_mask | input | 16 | Write-1-to-clear mask |
| cfg_rd | output | 8 | Configuration register read value |
| pend | output | 16 | Pending flags |
| int_pin | output | 1 | Interrupt output pin |

## Verification
A wrong filter decode or a wrong source index shows on `pend` at the first edge after the event: a flag is set in the wrong place or is missing. A wrong pin level shows on `int_pin` at that same edge.

A pulse counter that runs badly shows as a pulse that is one or more cycles too long or too short. It also shows as a second pulse after a merged event. All of these are visible within PULSE_CYC+1 cycles.

A missed detection of the global-enable edge shows as an `int_pin` that stays idle one cycle after `glb_en` rises while a flag is pending.

// File: rtl/irq_out_pkg.sv
package irq_out_pkg;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2,
        HS_NONE  = 2'd3
    } hs_kind_e;

    typedef struct packed {
        logic       pulse_mode;
        logic       act_high;
        logic [1:0] out_mode;
        logic [1:0] in_mode;
        logic [1:0] ctl_mode;
    } irq_cfg_t;

    // Filter field: bit 0 admits NAK, bit 1 admits STALL, ACK always passes
    function automatic logic hs_qualifies(input logic [1:0] mode, input hs_kind_e kind);
        case (kind)
            HS_ACK:   return 1'b1;
            HS_NAK:   return mode[0];
            HS_STALL: return mode[1];
            default:  return 1'b0;
        endcase
    endfunction

    function automatic int unsigned pulse_cycles(input int unsigned ns, input int unsigned mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

endpackage

// File: rtl/irq_evt_filter.sv
module irq_evt_filter
    import irq_out_pkg::*;
#(
    parameter int N_EP = 8,
    localparam int EPW = $clog2(N_EP),
    localparam int N_SRC = 2 * N_EP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_valid,
    input  logic [EPW-1:0]   ev_ep,
    input  logic             ev_in,
    input  hs_kind_e         ev_kind,
    input  logic [1:0]       ctl_mode,
    input  logic [1:0]       in_mode,
    input  logic [1:0]       out_mode,
    output logic [N_SRC-1:0] set_vec
);

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        localparam int EP  = s / 2;
        localparam bit DIR = (s % 2) == 1;
        logic [1:0] mode;
        if (EP == 0) begin : g_ctl
            assign mode = ctl_mode;
        end else if (DIR) begin : g_in
            assign mode = in_mode;
        end else begin : g_out
            assign mode = out_mode;
        end
        assign set_vec[s] = ev_valid && (ev_ep == EPW'(EP)) && (ev_in == DIR)
                            && hs_qualifies(mode, ev_kind);
    end

    // R4
    single_src_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_vec));

    // R5
    none_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_kind == HS_NONE) |-> (set_vec == '0));

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] set_vec,
    input  logic             clr_we,
    input  logic [N_SRC-1:0] clr_mask,
    output logic [N_SRC-1:0] pend_q,
    output logic [N_SRC-1:0] pend_nxt
);

    logic [N_SRC-1:0] clr_eff;

    assign clr_eff  = clr_we ? clr_mask : '0;
    assign pend_nxt = (pend_q & ~clr_eff) | set_vec;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_nxt;
    end

    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q & $past(clr_eff & ~set_vec)) == '0);

    // R4
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0);

endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
    parameter int N_SRC     = 16,
    parameter int PULSE_CYC = 3,
    localparam int CW = $clog2(PULSE_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse_mode,
    input  logic             act_high,
    input  logic             glb_en,
    input  logic [N_SRC-1:0] src_en,
    input  logic [N_SRC-1:0] set_vec,
    input  logic [N_SRC-1:0] pend_q,
    input  logic [N_SRC-1:0] pend_nxt,
    output logic             int_pin
);

    logic          glb_q;
    logic [CW-1:0] cnt_q, cnt_nxt;
    logic          trig, act_nxt;

    assign trig = pulse_mode && glb_en &&
                  ((|(set_vec & src_en)) || (!glb_q && |(pend_q & src_en)));

    always_comb begin
        if (cnt_q != '0)  cnt_nxt = cnt_q - 1'b1;
        else if (trig)    cnt_nxt = CW'(PULSE_CYC);
        else              cnt_nxt = '0;
    end

    assign act_nxt = pulse_mode ? (cnt_nxt != '0)
                                : (glb_en && |(pend_nxt & src_en));

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_q   <= 1'b0;
            cnt_q   <= '0;
            int_pin <= 1'b1;
        end else begin
            glb_q   <= glb_en;
            cnt_q   <= cnt_nxt;
            int_pin <= act_high ? act_nxt : !act_nxt;
        end
    end

    // R11
    pulse_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(PULSE_CYC));

    // R12
    pulse_merge_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen
    import irq_out_pkg::*;
#(
    parameter int N_EP     = 8,
    parameter int CLK_MHZ  = 48,
    parameter int PULSE_NS = 60,
    localparam int EPW       = $clog2(N_EP),
    localparam int N_SRC     = 2 * N_EP,
    localparam int PULSE_CYC = pulse_cycles(PULSE_NS, CLK_MHZ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_valid,
    input  logic [EPW-1:0]   ev_ep,
    input  logic             ev_in,
    input  logic [1:0]       ev_kind,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    input  logic [N_SRC-1:0] src_en,
    input  logic             glb_en,
    input  logic             clr_we,
    input  logic [N_SRC-1:0] clr_mask,
    output logic [7:0]       cfg_rd,
    output logic [N_SRC-1:0] pend,
    output logic             int_pin
);

    irq_cfg_t         cfg_q;
    logic [N_SRC-1:0] set_vec, pend_nxt;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_we) cfg_q <= irq_cfg_t'(cfg_wdata);
    end

    assign cfg_rd = cfg_q;

    irq_evt_filter #(.N_EP(N_EP)) u_filt (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (ev_valid),
        .ev_ep    (ev_ep),
        .ev_in    (ev_in),
        .ev_kind  (hs_kind_e'(ev_kind)),
        .ctl_mode (cfg_q.ctl_mode),
        .in_mode  (cfg_q.in_mode),
        .out_mode (cfg_q.out_mode),
        .set_vec  (set_vec)
    );

    irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .pend_q   (pend),
        .pend_nxt (pend_nxt)
    );

    irq_pin_drv #(.N_SRC(N_SRC), .PULSE_CYC(PULSE_CYC)) u_pin (
        .clk        (clk),
        .rst        (rst),
        .pulse_mode (cfg_q.pulse_mode),
        .act_high   (cfg_q.act_high),
        .glb_en     (glb_en),
        .src_en     (src_en),
        .set_vec    (set_vec),
        .pend_q     (pend),
        .pend_nxt   (pend_nxt),
        .int_pin    (int_pin)
    );

    // R8
    glb_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!glb_en) && $past(!cfg_q.pulse_mode)) |-> (int_pin == !$past(cfg_q.act_high)));

    // R10
    level_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(glb_en) && $past(!cfg_q.pulse_mode) && $past(src_en == '1) && (pend != '0))
            |-> (int_pin == $past(cfg_q.act_high)));

endmodule

// File: tb/sim_irq_out_gen.sv
module sim_irq_out_gen;

    localparam int CLK_NS = 20;
    localparam int NV = 12;

    logic        clk = 1'b0;
    logic        rst;
    logic        ev_valid;
    logic [2:0]  ev_ep;
    logic        ev_in;
    logic [1:0]  ev_kind;
    logic        cfg_we;
    logic [7:0]  cfg_wdata;
    logic [15:0] src_en;
    logic        glb_en;
    logic        clr_we;
    logic [15:0] clr_mask;
    logic [7:0]  cfg_rd;
    logic [15:0] pend;
    logic        int_pin;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_NS / 2) clk = ~clk;

    irq_out_gen u0 (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ep(ev_ep), .ev_in(ev_in),
        .ev_kind(ev_kind), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .src_en(src_en),
        .glb_en(glb_en), .clr_we(clr_we), .clr_mask(clr_mask), .cfg_rd(cfg_rd),
        .pend(pend), .int_pin(int_pin)
    );

    // {cfg byte, endpoint, in, kind, expected accept}
    localparam logic [14:0] VEC [NV] = '{
        {8'h40, 3'd0, 1'b0, 2'd0, 1'b1},
        {8'h40, 3'd0, 1'b0, 2'd1, 1'b0},
        {8'h41, 3'd0, 1'b0, 2'd1, 1'b1},
        {8'h41, 3'd0, 1'b1, 2'd2, 1'b0},
        {8'h42, 3'd0, 1'b1, 2'd2, 1'b1},
        {8'h40, 3'd3, 1'b1, 2'd1, 1'b0},
        {8'h44, 3'd3, 1'b1, 2'd1, 1'b1},
        {8'h44, 3'd3, 1'b0, 2'd1, 1'b0},
        {8'h70, 3'd5, 1'b0, 2'd2, 1'b1},
        {8'h70, 3'd5, 1'b1, 2'd2, 1'b0},
        {8'h4C, 3'd7, 1'b1, 2'd2, 1'b1},
        {8'h7F, 3'd2, 1'b0, 2'd3, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send(input logic [2:0] ep, input logic dir, input logic [1:0] kind);
        ev_valid = 1'b1; ev_ep = ep; ev_in = dir; ev_kind = kind;
        tick();
        ev_valid = 1'b0;
    endtask

    task automatic wcfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic clr(input logic [15:0] m);
        clr_we = 1'b1; clr_mask = m;
        tick();
        clr_we = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 50000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [14:0] v;
        int idx;
        rst = 1'b1; ev_valid = 0; ev_ep = 0; ev_in = 0; ev_kind = 0;
        cfg_we = 0; cfg_wdata = 0; src_en = 16'hFFFF; glb_en = 1'b1;
        clr_we = 0; clr_mask = 0;
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        chk("R1 pend", 32'(pend), 0);
        chk("R1 cfg", 32'(cfg_rd), 0);
        chk("R1 pin", 32'(int_pin), 1);

        // table walk: filter decode and source indexing
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            idx = int'(v[6:4]) * 2 + int'(v[3]);
            clr_we = 1'b1; clr_mask = 16'hFFFF; cfg_we = 1'b1; cfg_wdata = v[14:7];
            tick();
            clr_we = 1'b0; cfg_we = 1'b0;
            send(v[6:4], v[3], v[2:1]);
            if (v[2:1] == 2'd3) begin
                chk("R5 pend", 32'(pend), 0);
                chk("R5 pin", 32'(int_pin), 0);
            end else if (v[6:4] == 3'd0) begin
                chk("R3 pend", 32'(pend), v[0] ? (32'd1 << idx) : 0);
                chk("R3 pin", 32'(int_pin), 32'(v[0]));
            end else begin
                chk("R4 pend", 32'(pend), v[0] ? (32'd1 << idx) : 0);
                chk("R4 pin", 32'(int_pin), 32'(v[0]));
            end
        end

        // R2 readback
        wcfg(8'h40);
        chk("R2 cfg", 32'(cfg_rd), 32'h40);
        clr(16'hFFFF);

        // R7 masked source recorded but silent
        src_en = 16'hFFFE;
        send(3'd0, 1'b0, 2'd0);
        chk("R7 pend", 32'(pend), 1);
        chk("R7 pin masked", 32'(int_pin), 0);
        src_en = 16'hFFFF;
        tick();
        chk("R7 pin unmasked", 32'(int_pin), 1);

        // R6 clear, and set wins over clear
        clr(16'h0001);
        chk("R6 pend", 32'(pend), 0);
        chk("R6 pin", 32'(int_pin), 0);
        clr_we = 1'b1; clr_mask = 16'h0001;
        send(3'd0, 1'b0, 2'd0);
        clr_we = 1'b0;
        chk("R6 set wins", 32'(pend), 1);
        clr(16'hFFFF);

        // R8 global gate, R9 level enable
        glb_en = 1'b0;
        send(3'd1, 1'b1, 2'd0);
        chk("R8 pend", 32'(pend), 32'h8);
        chk("R8 pin", 32'(int_pin), 0);
        glb_en = 1'b1;
        tick();
        chk("R9 level pin", 32'(int_pin), 1);
        clr(16'hFFFF);
        chk("R10 pin released", 32'(int_pin), 0);

        // R10 active-low level
        wcfg(8'h00);
        tick();
        chk("R10 idle low pol", 32'(int_pin), 1);
        send(3'd0, 1'b0, 2'd0);
        chk("R10 active low", 32'(int_pin), 0);
        clr(16'hFFFF);
        chk("R10 release low pol", 32'(int_pin), 1);

        // R11 pulse length
        wcfg(8'hC0);
        clr(16'hFFFF);
        chk("R11 idle", 32'(int_pin), 0);
        send(3'd2, 1'b0, 2'd0);
        chk("R11 c1", 32'(int_pin), 1);
        tick(); chk("R11 c2", 32'(int_pin), 1);
        tick(); chk("R11 c3", 32'(int_pin), 1);
        tick(); chk("R11 end", 32'(int_pin), 0);
        chk("R11 sticky", 32'(pend), 32'h10);

        // R12 merge
        clr(16'hFFFF);
        send(3'd2, 1'b0, 2'd0);
        send(3'd2, 1'b0, 2'd0);
        chk("R12 c2", 32'(int_pin), 1);
        tick(); chk("R12 c3", 32'(int_pin), 1);
        tick(); chk("R12 end", 32'(int_pin), 0);
        tick(); chk("R12 no repeat", 32'(int_pin), 0);

        // R13 no pulse while gated, R9 pulse on enable
        clr(16'hFFFF);
        glb_en = 1'b0;
        send(3'd3, 1'b1, 2'd0);
        chk("R13 gated", 32'(int_pin), 0);
        tick(); chk("R13 later", 32'(int_pin), 0);
        glb_en = 1'b1;
        tick(); chk("R9 pulse c1", 32'(int_pin), 1);
        tick(); chk("R9 pulse c2", 32'(int_pin), 1);
        tick(); chk("R9 pulse c3", 32'(int_pin), 1);
        tick(); chk("R9 pulse end", 32'(int_pin), 0);

        // R11 active-low pulse
        wcfg(8'h80);
        clr(16'hFFFF);
        chk("R11 low idle", 32'(int_pin), 1);
        send(3'd0, 1'b0, 2'd0);
        chk("R11 low pulse", 32'(int_pin), 0);

        // R1 reset mid-run
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        chk("R1 pend after rst", 32'(pend), 0);
        chk("R1 cfg after rst", 32'(cfg_rd), 0);
        chk("R1 pin after rst", 32'(int_pin), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule